// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO with Active-Low Level Flags

This block is a small first-in first-out buffer, sixteen words deep and five bits wide, that sits between two unrelated clock domains. A producer in the load domain pushes a word by raising its request for one load-clock cycle, and a consumer in the unload domain removes the head word by raising its request for one unload-clock cycle. The oldest stored word is always on the data outputs, so the consumer can look at the head without removing it, and a word that is never unloaded stays there.

Four active-low flags report the fill level. The full and almost-full flags are computed in the load domain. The empty and almost-empty flags are computed in the unload domain. Each domain's pointer crosses to the other domain as a Gray code through a two-flop synchronizer. A flag raised by the far side's activity therefore lags by up to three cycles of the observing clock. An output enable switches the data outputs to high impedance and does not touch the flags. An asynchronous active-low reset clears both pointers.

Top module: `dcfifo_ft`

## Requirements
- R1: A word on `d` is stored on a rising edge of `ld_clk` at which `ld_req` is high and `full_n` is high. The buffer holds up to 16 words of 5 bits.
- R2: Words leave in the order they were stored. A rising edge of `ul_clk` with `ul_req` high and `empty_n` high removes the head word, and `q` then shows the next word.
- R3: A load request while `full_n` is low stores nothing, and no such word ever reaches `q`.
- R4: An unload request while `empty_n` is low has no effect on the pointers, the flags or `q`.
- R5: `full_n` is low exactly when 16 words are held. `afull_n` is low exactly when 15 words are held. Both are high otherwise.
- R6: `empty_n` is low exactly when no word is held. `aempty_n` is low exactly when one word is held. Both are high otherwise.
- R7: While `rst_n` is low, both pointers are cleared, `empty_n` is low, and `full_n`, `afull_n` and `aempty_n` are high. This holds whatever the previous contents were.
- R8: After a write into an empty buffer, `empty_n` rises and the written word appears on `q` within 3 `ul_clk` cycles, with no unload.
- R9: `q` is high impedance (all bits z) while `oe` is low and is a non-inverted copy of the head word while `oe` is high. `oe` has no effect on any flag.
- R10: While the buffer is empty, `q` holds the last word that was unloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ld_clk | input | 1 | Load-domain clock |
| ld_req | input | 1 | Store `d` on this load-clock edge |
| d | input | 5 | Word to store |
| ul_clk | input | 1 | Unload-domain clock, unrelated to `ld_clk` |
| ul_req | input | 1 | Remove the head word on this unload-clock edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| oe | input | 1 | Output enable; low drives `q` to high impedance |
| q | output | 5 | Head word (fall-through) |
| full_n | output | 1 | Low when 16 words are held |
| afull_n | output | 1 | Low when exactly 15 words are held |
| empty_n | output | 1 | Low when no word is held |
| aempty_n | output | 1 | Low when exactly one word is held |

## Verification
A store and a removal can land together. They are provoked by two concurrent processes on clocks of 8 ns and 13 ns. In one phase the writer outruns the reader, so the buffer sits at full while unloads free slots. In the other phase the reader outruns the writer, so unloads meet fresh stores at the empty and one-word levels. Each process decides whether its request takes effect from the flag of its own domain, sampled at the falling edge just before the committing edge. A queue model checks every unloaded word against `q`. This also proves that no word was lost, duplicated or accepted while full.

// File: rtl/dcfifo_ft.sv
`timescale 1ns/1ps
module dcfifo_ft #(
  parameter int W     = 5,
  parameter int DEPTH = 16
) (
  input  logic         ld_clk,
  input  logic         ld_req,
  input  logic [W-1:0] d,
  input  logic         ul_clk,
  input  logic         ul_req,
  input  logic         rst_n,
  input  logic         oe,
  output logic [W-1:0] q,
  output logic         full_n,
  output logic         afull_n,
  output logic         empty_n,
  output logic         aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULLV = PW'(DEPTH);
  localparam logic [PW-1:0] ONE   = PW'(1);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2;
  logic [PW-1:0] rbin, rgray, wg_s1, wg_s2;
  logic [W-1:0]  last, data;
  logic [PW-1:0] wcount, rcount, wnext, rnext;
  logic          wr_ok, rd_ok;

  assign wcount = wbin - g2b(rg_s2);
  assign rcount = g2b(wg_s2) - rbin;
  assign wr_ok  = ld_req && (wcount != FULLV);
  assign rd_ok  = ul_req && (rcount != '0);
  assign wnext  = wbin + ONE;
  assign rnext  = rbin + ONE;

  always_ff @(posedge ld_clk or negedge rst_n)
    if (!rst_n) begin
      wbin <= '0; wgray <= '0; rg_s1 <= '0; rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_ok) begin
        wbin  <= wnext;
        wgray <= wnext ^ (wnext >> 1);
      end
    end

  always_ff @(posedge ld_clk)
    if (rst_n && wr_ok) mem[wbin[AW-1:0]] <= d;

  always_ff @(posedge ul_clk or negedge rst_n)
    if (!rst_n) begin
      rbin <= '0; rgray <= '0; wg_s1 <= '0; wg_s2 <= '0; last <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (rd_ok) begin
        rbin  <= rnext;
        rgray <= rnext ^ (rnext >> 1);
        last  <= mem[rbin[AW-1:0]];
      end
    end

  assign data     = (rcount == '0) ? last : mem[rbin[AW-1:0]];
  assign q        = oe ? data : {W{1'bz}};
  assign full_n   = (wcount != FULLV);
  assign afull_n  = (wcount != FULLV - ONE);
  assign empty_n  = (rcount != '0);
  assign aempty_n = (rcount != ONE);

  AST_NO_OVERFLOW: assert property (@(posedge ld_clk) disable iff (!rst_n)
    wcount <= FULLV);                                                    // R3
  AST_FULL_HOLD: assert property (@(posedge ld_clk) disable iff (!rst_n)
    (ld_req && !full_n) |=> $stable(wbin));                              // R3
  AST_NO_UNDERFLOW: assert property (@(posedge ul_clk) disable iff (!rst_n)
    rcount <= FULLV);                                                    // R4
  AST_EMPTY_HOLD: assert property (@(posedge ul_clk) disable iff (!rst_n)
    (ul_req && !empty_n) |=> $stable(rbin));                             // R4
  AST_Q_HOLD: assert property (@(posedge ul_clk) disable iff (!rst_n)
    (!empty_n && $past(!empty_n)) |-> $stable(data));                    // R10
endmodule

// File: tb/dcfifo_ft_bench.sv
`timescale 1ns/1ps
module dcfifo_ft_bench;
  logic ld_clk = 0, ul_clk = 0, ld_req = 0, ul_req = 0, rst_n = 0, oe = 1;
  logic [4:0] d = '0;
  wire  [4:0] q;
  wire full_n, afull_n, empty_n, aempty_n;
  int checks = 0, fails = 0;
  logic [4:0] model[$];
  logic [4:0] lastrd;

  always #4   ld_clk = ~ld_clk;
  always #6.5 ul_clk = ~ul_clk;

  dcfifo_ft u_dcfifo_ft (.ld_clk, .ld_req, .d, .ul_clk, .ul_req, .rst_n, .oe, .q,
                         .full_n, .afull_n, .empty_n, .aempty_n);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge ul_clk);
  endtask

  task automatic flags(input string req);
    int n = model.size();
    chk({req, " full_n"},   full_n,   n != 16);
    chk({req, " afull_n"},  afull_n,  n != 15);
    chk({req, " empty_n"},  empty_n,  n != 0);
    chk({req, " aempty_n"}, aempty_n, n != 1);
  endtask

  task automatic wr(input logic [4:0] v);
    @(negedge ld_clk);
    if (full_n) model.push_back(v);
    ld_req = 1; d = v;
    @(negedge ld_clk);
    ld_req = 0;
  endtask

  task automatic rd();
    @(negedge ul_clk);
    if (empty_n) begin
      chk("R2 order", q, model[0]);
      lastrd = model.pop_front();
    end
    ul_req = 1;
    @(negedge ul_clk);
    ul_req = 0;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #3;
    chk("R7 reset empty_n", empty_n, 0);
    chk("R7 reset full_n", full_n, 1);
    chk("R7 reset afull_n", afull_n, 1);
    chk("R7 reset aempty_n", aempty_n, 1);
    #30 rst_n = 1;
    settle();
    rd();                                   // R4 unload while empty
    settle();
    flags("R4");

    wr(5'h13);
    begin
      int k = 0;
      while (!empty_n && k < 4) begin @(negedge ul_clk); k++; end
      chk("R8 latency within 3", k <= 3, 1);
    end
    settle();
    chk("R8 fall-through q", q, 5'h13);
    flags("R6 one word");
    for (int i = 1; i < 15; i++) wr(5'(i * 3));
    settle();
    flags("R5 fifteen");
    wr(5'h0a);
    settle();
    flags("R5 sixteen");
    wr(5'h1f);                              // R3 store while full
    settle();
    flags("R3 full ignore");
    chk("R3 size", model.size(), 16);

    oe = 0;
    #1;
    chk("R9 high-z", q === 5'bzzzzz, 1);
    flags("R9 flags under oe low");
    oe = 1;
    #1;
    chk("R9 head", q, 5'h13);

    for (int i = 0; i < 16; i++) begin
      rd();
      if (model.size() == 1) begin settle(); flags("R6 almost empty"); end
    end
    settle();
    flags("R6 drained");
    chk("R10 hold last", q, lastrd);
    rd();
    settle();
    chk("R4 q unchanged", q, lastrd);
    flags("R4 empty ignore");

    for (int i = 0; i < 3; i++) wr(5'(i + 20));
    settle();
    rst_n = 0;
    model.delete();
    #2;
    flags("R7 reset with data");
    #20 rst_n = 1;
    settle();
    flags("R7 after release");

    for (int ph = 0; ph < 2; ph++) begin
      fork
        begin
          int sent = 0, cyc = 0;
          while (sent < 60) begin
            @(negedge ld_clk);
            ld_req = 0;
            cyc++;
            if (ph == 0 || cyc % 4 == 0) begin
              d = 5'(sent * 7 + 3 + ph);
              if (full_n) begin model.push_back(d); sent++; end
              ld_req = 1;
            end
          end
          @(negedge ld_clk); ld_req = 0;
        end
        begin
          int got = 0, cyc = 0;
          while (got < 60) begin
            @(negedge ul_clk);
            ul_req = 0;
            cyc++;
            if (ph == 1 || cyc % 3 == 0) begin
              if (empty_n) begin
                chk("R1 R2 stream order", q, model[0]);
                lastrd = model.pop_front();
                got++;
              end
              ul_req = 1;
            end
          end
          @(negedge ul_clk); ul_req = 0;
        end
      join
      settle();
      flags("R1 stream end");
      chk("R10 stream hold", q, lastrd);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule